// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control half of a 10-bit successive-approximation converter. It sits in front of an eight-way analog input multiplexer, a trial DAC and a comparator. Each conversion samples one multiplexer channel. It then resolves the code by binary search, presenting a trial code and reading back one comparator decision per bit. Finally it loads the finished code into a pair of byte-wide result registers, using one of two layouts.

A conversion can be requested by a software start bit or by a hardware start strobe. A continuous mode re-arms the converter on the same channel after every result. The power-on bit gates the whole engine. After it is raised, a settling counter must expire before any start is honoured. Dropping it aborts whatever is in flight. A completion sets an end-of-conversion flag, which can drive an interrupt. Software clears the flag by reading the high result byte or by writing a clear bit.

The control engine is a five-state machine:
- IDLE: leaves for SAMPLE on an accepted start.
- SAMPLE: leaves for TRIAL after the sampling count.
- TRIAL: handles each bit in turn. After the last bit it goes to PAD if a minimum-length pad is needed, and to DONE otherwise.
- PAD: leaves for DONE when the pad count expires.
- DONE: lasts one cycle. It returns to SAMPLE in continuous mode and to IDLE otherwise.

Any state falls back to IDLE while the power-on bit is low.

Top module: `sar_seq`

## Requirements
- R1: Bits are resolved from bit 9 down to bit 0. Each bit holds its trial code for CLK_PER_BIT clocks, and the decision is taken on the last of them. `cmp_in`=1 keeps the bit and 0 drops it. The next lower bit is set in the same update. `trial_code` is 0 while sampling and holds the final code after the last decision.
- R2: `mux_sel` takes `ch_sel` (3 bits, channel 0–7) only when a start is accepted from IDLE. Changes of `ch_sel` during a conversion, or between continuous-mode conversions, have no effect on `mux_sel`.
- R3: In IDLE with `ready` high, either `sw_start` or `hw_start` high at a clock edge starts a conversion.
- R4: A start request while `busy` is high is ignored: the running conversion completes on its normal schedule.
- R5: While `pwr_on` is low, starts are discarded, `busy` and `ready` are low and `trial_code` is 0. Dropping `pwr_on` mid-conversion aborts it with no result and no end-of-conversion.
- R6: `ready` rises only after `pwr_on` has been high for SETTLE_CLKS clock edges. It falls as soon as `pwr_on` falls, and the count restarts on the next power-up.
- R7: `busy` lasts SAMPLE_CLKS + 10·CLK_PER_BIT + PAD + 1 cycles. PAD is the amount that lifts the sample-plus-bit time to MIN_CONV_CLKS, or 0 if that time already meets it. The completion step lasts exactly one cycle.
- R8: With `cont_en` high at completion, the next conversion starts on the cycle after completion on the same channel, without a new start request.
- R9: With `fmt_right`=0 at completion, `res_hi` = result[9:2] and `res_lo` = {result[1:0], 6'b0}.
- R10: With `fmt_right`=1 at completion, `res_hi` = {6'b0, result[9:8]} and `res_lo` = result[7:0].
- R11: `eoc` is set on the edge that ends the completion cycle. It is cleared at an edge with `rd_hi` or `eoc_clr` high. If a set and a clear fall on the same edge, the set wins.
- R12: `irq` is high exactly when `eoc` and `irq_en` are both high.
- R13: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Converter enable; low powers down and aborts |
| sw_start | input | 1 | Software start bit (one-cycle write) |
| hw_start | input | 1 | Hardware start strobe |
| cont_en | input | 1 | Continuous conversion mode |
| ch_sel | input | 3 | Requested input channel |
| fmt_right | input | 1 | 1 = right-justified result, 0 = left-justified |
| irq_en | input | 1 | Interrupt enable |
| rd_hi | input | 1 | Strobe marking a read of the high result byte |
| eoc_clr | input | 1 | Write strobe clearing the end-of-conversion flag |
| cmp_in | input | 1 | Comparator decision: 1 when input is at or above trial code |
| mux_sel | output | 3 | Multiplexer channel in use |
| trial_code | output | 10 | Code presented to the trial DAC |
| ready | output | 1 | Settling time has elapsed |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | End-of-conversion flag |
| irq | output | 1 | Interrupt request |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |

## Verification
The bench builds the sequencer with a two-clock sample, two clocks per bit, five settling clocks and a thirty-clock minimum. With those values the pad state is entered on every conversion, and a full conversion fits in 31 cycles. This brings both power-up settling and several back-to-back continuous conversions within a short run. It also makes it cheap to land a clear strobe on the very edge where the flag is set. An ideal comparator is driven from a per-channel input value. This lets the reference model predict every trial code without knowing the search logic, including the all-ones and all-zeros codes.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_TRIAL,
        ST_PAD,
        ST_DONE
    } sar_state_e;
endpackage

// File: rtl/sar_settle.sv
module sar_settle #(
    parameter int SETTLE_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    output logic ready
);
    localparam int SW = (SETTLE_CLKS > 0) ? $clog2(SETTLE_CLKS + 1) : 1;

    logic [SW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (!pwr_on) begin
            wait_cnt <= '0;
        end else if (wait_cnt != SW'(SETTLE_CLKS)) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assign ready = pwr_on && (wait_cnt == SW'(SETTLE_CLKS));
endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_pkg::*;
#(
    parameter int RES_W         = 10,
    parameter int CH_W          = 3,
    parameter int CLK_PER_BIT   = 4,
    parameter int SAMPLE_CLKS   = 4,
    parameter int MIN_CONV_CLKS = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             ready,
    input  logic             start_req,
    input  logic             cont_en,
    input  logic [CH_W-1:0]  ch_sel,
    input  logic             cmp_in,
    output logic [CH_W-1:0]  mux_sel,
    output logic [RES_W-1:0] trial_code,
    output logic             busy,
    output logic             done
);
    localparam int BASE_CLKS = SAMPLE_CLKS + RES_W * CLK_PER_BIT;
    localparam int PAD_CLKS  = (MIN_CONV_CLKS > BASE_CLKS) ? MIN_CONV_CLKS - BASE_CLKS : 0;
    localparam int M1        = (SAMPLE_CLKS > CLK_PER_BIT) ? SAMPLE_CLKS : CLK_PER_BIT;
    localparam int CMAX      = (PAD_CLKS > M1) ? PAD_CLKS : M1;
    localparam int CNT_W     = $clog2(CMAX + 1);
    localparam int IDX_W     = $clog2(RES_W);
    localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(SAMPLE_CLKS - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(CLK_PER_BIT - 1);
    localparam logic [CNT_W-1:0] PAD_LAST = CNT_W'((PAD_CLKS > 0) ? PAD_CLKS - 1 : 0);

    sar_state_e st, nxt;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] sar;
    logic [CH_W-1:0]  chan;
    logic             bit_end;

    assign bit_end = (st == ST_TRIAL) && (cnt == BIT_LAST);

    // next-state decision
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   if (ready && start_req) nxt = ST_SAMPLE;
            ST_SAMPLE: if (cnt == SMP_LAST) nxt = ST_TRIAL;
            ST_TRIAL:  if (bit_end && idx == '0) nxt = (PAD_CLKS > 0) ? ST_PAD : ST_DONE;
            ST_PAD:    if (cnt == PAD_LAST) nxt = ST_DONE;
            ST_DONE:   nxt = cont_en ? ST_SAMPLE : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!pwr_on) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // counter, search register and channel latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            idx  <= '0;
            sar  <= '0;
            chan <= '0;
        end else if (!pwr_on) begin
            cnt <= '0;
            sar <= '0;
        end else begin
            if (st == ST_IDLE || st != nxt || bit_end) cnt <= '0;
            else                                      cnt <= cnt + 1'b1;

            if (nxt == ST_SAMPLE && st != ST_SAMPLE) begin
                sar <= '0;
                if (st == ST_IDLE) chan <= ch_sel;
            end
            if (st == ST_SAMPLE && nxt == ST_TRIAL) begin
                sar <= {1'b1, {(RES_W-1){1'b0}}};
                idx <= IDX_W'(RES_W - 1);
            end
            if (bit_end) begin
                sar[idx] <= cmp_in;
                if (idx != '0) begin
                    sar[idx - 1'b1] <= 1'b1;
                    idx <= idx - 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        mux_sel    = chan;
        trial_code = sar;
        busy       = (st != ST_IDLE);
        done       = (st == ST_DONE) && pwr_on;
    end
endmodule

// File: rtl/sar_pack.sv
module sar_pack #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             fmt_right,
    input  logic [RES_W-1:0] result,
    input  logic             rd_hi,
    input  logic             eoc_clr,
    input  logic             irq_en,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo,
    output logic             eoc,
    output logic             irq
);
    localparam int PADW = 16 - RES_W;

    logic [15:0] left_j, right_j;

    assign left_j  = {result, {PADW{1'b0}}};
    assign right_j = {{PADW{1'b0}}, result};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hi <= '0;
            res_lo <= '0;
            eoc    <= 1'b0;
        end else begin
            if (done) begin
                res_hi <= fmt_right ? right_j[15:8] : left_j[15:8];
                res_lo <= fmt_right ? right_j[7:0]  : left_j[7:0];
            end
            if (done)                  eoc <= 1'b1;
            else if (rd_hi || eoc_clr) eoc <= 1'b0;
        end
    end

    assign irq = eoc && irq_en;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int RES_W         = 10,
    parameter int CH_W          = 3,
    parameter int CLK_PER_BIT   = 4,
    parameter int SAMPLE_CLKS   = 4,
    parameter int SETTLE_CLKS   = 64,
    parameter int MIN_CONV_CLKS = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             sw_start,
    input  logic             hw_start,
    input  logic             cont_en,
    input  logic [CH_W-1:0]  ch_sel,
    input  logic             fmt_right,
    input  logic             irq_en,
    input  logic             rd_hi,
    input  logic             eoc_clr,
    input  logic             cmp_in,
    output logic [CH_W-1:0]  mux_sel,
    output logic [RES_W-1:0] trial_code,
    output logic             ready,
    output logic             busy,
    output logic             eoc,
    output logic             irq,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo
);
    logic start_req;
    logic done_w;

    assign start_req = sw_start || hw_start;

    sar_settle #(.SETTLE_CLKS(SETTLE_CLKS)) u_settle (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .ready(ready)
    );

    sar_core #(
        .RES_W(RES_W), .CH_W(CH_W), .CLK_PER_BIT(CLK_PER_BIT),
        .SAMPLE_CLKS(SAMPLE_CLKS), .MIN_CONV_CLKS(MIN_CONV_CLKS)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .ready(ready),
        .start_req(start_req), .cont_en(cont_en), .ch_sel(ch_sel),
        .cmp_in(cmp_in), .mux_sel(mux_sel), .trial_code(trial_code),
        .busy(busy), .done(done_w)
    );

    sar_pack #(.RES_W(RES_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .done(done_w), .fmt_right(fmt_right),
        .result(trial_code), .rd_hi(rd_hi), .eoc_clr(eoc_clr),
        .irq_en(irq_en), .res_hi(res_hi), .res_lo(res_lo),
        .eoc(eoc), .irq(irq)
    );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwr_on,
    input logic            start_req,
    input logic            ready,
    input logic            busy,
    input logic            done,
    input logic [CH_W-1:0] mux_sel,
    input logic            eoc,
    input logic            irq,
    input logic            rd_hi
);
    // R5
    pwr_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !busy);
    // R6
    no_start_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ready) |=> !busy);
    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req && !done && pwr_on) |=> busy);
    // R2
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_sel));
    // R11
    eoc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> eoc);
    // R12
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && !done) |=> !irq);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind sar_seq sar_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .start_req(start_req),
    .ready(ready), .busy(busy), .done(done_w), .mux_sel(mux_sel),
    .eoc(eoc), .irq(irq), .rd_hi(rd_hi)
);

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
    localparam int CLK_PER = 10;
    localparam int SMP = 2, CPB = 2, SET = 5, MINC = 30;
    localparam int BASE = SMP + 10 * CPB;
    localparam int PADC = (MINC > BASE) ? MINC - BASE : 0;
    localparam int TOTAL = BASE + PADC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on = 0, sw_start = 0, hw_start = 0, cont_en = 0;
    logic [2:0] ch_sel = 0;
    logic fmt_right = 0, irq_en = 0, rd_hi = 0, eoc_clr = 0;
    logic cmp_in;
    logic [2:0] mux_sel;
    logic [9:0] trial_code;
    logic ready, busy, eoc, irq;
    logic [7:0] res_hi, res_lo;
    logic [9:0] vin [8];

    int vectors = 0, errors = 0;
    string scen = "R13";

    // model state
    int m_set = 0, m_ph = -1;
    logic [2:0] m_ch = 0;
    logic [9:0] m_code = 0;
    logic m_eoc = 0, m_fmt = 0;
    logic [7:0] m_hi = 0, m_lo = 0;

    always #(CLK_PER/2) clk = ~clk;

    assign cmp_in = (vin[mux_sel] >= trial_code);

    sar_seq #(.CLK_PER_BIT(CPB), .SAMPLE_CLKS(SMP), .SETTLE_CLKS(SET),
              .MIN_CONV_CLKS(MINC)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .sw_start(sw_start),
        .hw_start(hw_start), .cont_en(cont_en), .ch_sel(ch_sel),
        .fmt_right(fmt_right), .irq_en(irq_en), .rd_hi(rd_hi),
        .eoc_clr(eoc_clr), .cmp_in(cmp_in), .mux_sel(mux_sel),
        .trial_code(trial_code), .ready(ready), .busy(busy), .eoc(eoc),
        .irq(irq), .res_hi(res_hi), .res_lo(res_lo)
    );

    function automatic logic [9:0] code_at(int t, int v);
        int k;
        if (t < SMP) return 10'd0;
        if (t < BASE) begin
            k = 9 - (t - SMP) / CPB;
            return 10'((v & ~((1 << (k + 1)) - 1)) | (1 << k));
        end
        return 10'(v);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t", req, scen, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic fin;
        logic rdy;
        int v;
        @(posedge clk);
        fin = 1'b0;
        if (!rst_n) begin
            m_set = 0; m_ph = -1; m_ch = 0; m_code = 0; m_eoc = 0;
            m_hi = 0; m_lo = 0;
        end else begin
            rdy = pwr_on && (m_set == SET);
            if (!pwr_on) begin
                m_set = 0; m_ph = -1; m_code = 0;
            end else begin
                if (m_ph == -1) begin
                    if (rdy && (sw_start || hw_start)) begin
                        m_ph = 0; m_ch = ch_sel; m_code = 0;
                    end
                end else if (m_ph == TOTAL - 1) begin
                    fin = 1'b1;
                    v = int'(vin[m_ch]);
                    m_fmt = fmt_right;
                    if (fmt_right) begin m_hi = 8'(v >> 8); m_lo = 8'(v); end
                    else           begin m_hi = 8'(v >> 2); m_lo = 8'((v & 3) << 6); end
                    if (cont_en) begin m_ph = 0; m_code = 0; end
                    else m_ph = -1;
                end else begin
                    m_ph++;
                    m_code = code_at(m_ph, int'(vin[m_ch]));
                end
                if (m_set < SET) m_set++;
            end
            if (fin) m_eoc = 1'b1;
            else if (rd_hi || eoc_clr) m_eoc = 1'b0;
        end
        @(negedge clk);
        vectors++;
        chk("R6", "ready", int'(ready), int'(pwr_on && m_set == SET));
        chk("R7", "busy", int'(busy), int'(m_ph != -1));
        chk("R1", "trial_code", int'(trial_code), int'(m_code));
        chk("R2", "mux_sel", int'(mux_sel), int'(m_ch));
        chk("R11", "eoc", int'(eoc), int'(m_eoc));
        chk("R12", "irq", int'(irq), int'(m_eoc && irq_en));
        chk(m_fmt ? "R10" : "R9", "res_hi", int'(res_hi), int'(m_hi));
        chk(m_fmt ? "R10" : "R9", "res_lo", int'(res_lo), int'(m_lo));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_sw();
        sw_start = 1; tick(); sw_start = 0;
    endtask

    initial begin
        #(CLK_PER * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        vin[0] = 10'h001; vin[1] = 10'h155; vin[2] = 10'h0AA; vin[3] = 10'h2A5;
        vin[4] = 10'h200; vin[5] = 10'h3FF; vin[6] = 10'h1FF; vin[7] = 10'h000;
        // R13: reset state
        scen = "R13";
        run(3);
        rst_n = 1;
        run(2);
        // R5/R6: starts while off or settling are discarded
        scen = "R5";
        pulse_sw(); run(2);
        pwr_on = 1;
        scen = "R6";
        pulse_sw(); run(1); pulse_sw(); run(4);
        // R3/R9: software start, left-justified
        scen = "R3";
        ch_sel = 3; fmt_right = 0;
        pulse_sw(); ch_sel = 6;
        run(TOTAL + 3);
        // R11: read of high byte clears flag
        scen = "R11";
        rd_hi = 1; tick(); rd_hi = 0; run(2);
        // R4/R10/R12: hardware start, right-justified, starts while busy
        scen = "R4";
        ch_sel = 5; fmt_right = 1; irq_en = 1;
        hw_start = 1; tick(); hw_start = 0;
        run(5); pulse_sw(); run(8); hw_start = 1; tick(); hw_start = 0;
        // R11: clear held across completion edge, set wins
        scen = "R11";
        eoc_clr = 1;
        run(TOTAL);
        eoc_clr = 0;
        run(3);
        eoc_clr = 1; tick(); eoc_clr = 0; run(2);
        // R8/R2: continuous mode, channel changes ignored
        scen = "R8";
        ch_sel = 0; cont_en = 1; fmt_right = 0;
        pulse_sw(); ch_sel = 4;
        run(TOTAL * 2 + 10);
        cont_en = 0;
        run(TOTAL + 4);
        // R5: power drop aborts a conversion
        scen = "R5";
        ch_sel = 4; pulse_sw(); run(12);
        pwr_on = 0; run(3);
        pwr_on = 1;
        scen = "R6";
        ch_sel = 7; pulse_sw(); run(SET);
        // R1: all-zeros and all-ones inputs
        scen = "R1";
        pulse_sw(); run(TOTAL + 2);
        ch_sel = 5; fmt_right = 0; pulse_sw(); run(TOTAL + 2);
        ch_sel = 1; fmt_right = 1; hw_start = 1; tick(); hw_start = 0; run(TOTAL + 2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule